// File: doc/BRIEF.md
# Tone Steering and Output Latch

This block sits behind a dual-tone recognizer and decides when a recognized tone counts as a real key press. It takes a raw "tone seen" flag and the 4-bit code that goes with it. It qualifies the flag over time and hands a stable code to a microcontroller bus.

A registered early-steering output follows the raw flag. A single up/down counter, advanced by a tick divided down from the reference clock, measures how long the tone has been present. When the count reaches a run-time acceptance limit, the code is captured into an output register. The data-valid output rises one clock later. Once data-valid is high, the counter is reloaded with a separate release limit for as long as the tone is present. While the tone is absent, the counter counts down, and data-valid drops only when the counter reaches zero. Short drop-outs are therefore bridged.

The captured code stays on the data pins after data-valid falls, until the next acceptance. The data pins float when output-enable is low. A power-down input clears all steering state but keeps the captured code.

Top module: `tone_steer_latch`

## Requirements
- R1: After reset, data_valid and early_steer are 0, and code_out reads 4'h0 while out_en is 1.
- R2: Outside power-down, early_steer equals the value tone_raw had one clock earlier.
- R3: With acc_ticks = A > 0 and D clocks per tick, data_valid rises between (A-1)*D+4 and A*D+3 clock edges after tone_raw goes high, counting the first edge that samples the high tone as 1.
- R4: The code on code_raw is captured exactly one clock before data_valid rises, so code_out already shows the new code on the cycle before the rise.
- R5: A tone that ends before it has been present for acc_ticks ticks never raises data_valid.
- R6: With rel_ticks = L > 0, data_valid falls between (L-1)*D+3 and L*D+2 clock edges after tone_raw goes low. An absence shorter than that leaves data_valid high.
- R7: After data_valid falls, code_out keeps the last captured code, even if code_raw changes, until the next acceptance.
- R8: A change on code_raw while data_valid is high does not alter code_out.
- R9: When out_en is 0, code_out is not driven (high impedance). When out_en is 1, code_out carries the captured code.
- R10: While pwr_down is 1, data_valid and early_steer are 0 one clock later and the captured code is kept. After pwr_down returns to 0, a present tone needs the full acceptance time of R3 again.
- R11: With acc_ticks = 0, data_valid rises exactly 3 edges after tone_raw goes high. With rel_ticks = 0, data_valid falls exactly 2 edges after tone_raw goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Clears steering state and holds the tick divider |
| tone_raw | input | 1 | Raw tone-present flag from the recognizer |
| code_raw | input | CODE_W | Code from the recognizer |
| acc_ticks | input | TICK_W | Tone-present time, in ticks |
| rel_ticks | input | TICK_W | Tone-absent time, in ticks |
| out_en | input | 1 | Drive enable for code_out |
| early_steer | output | 1 | Registered copy of tone_raw |
| data_valid | output | 1 | Qualified tone strobe |
| code_out | output | CODE_W | Captured code, high impedance when out_en is 0 |

## Verification
Some results are due at a fixed clock: early_steer one edge after tone_raw, and the clearing by power-down one edge after pwr_down. The zero-limit cases are also fixed: a rise at the third edge and a fall at the second. The bench samples these at exactly that edge. Rises and falls with non-zero limits depend on the phase of the tick divider. For these, the bench counts edges from the stimulus until the edge on which data_valid changes, and compares that count with the window in R3 or R6. Code capture is checked on the sample just before the rise. Hold behaviour is checked on every cycle of a drop-out or power-down interval.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_HELD  = 2'd2
    } steer_state_e;

    typedef enum logic [2:0] {
        CNT_HOLD  = 3'd0,
        CNT_UP    = 3'd1,
        CNT_DOWN  = 3'd2,
        CNT_LOAD  = 3'd3,
        CNT_CLEAR = 3'd4
    } cnt_op_e;

    typedef struct packed {
        logic est;
        logic dv;
        logic load;
    } steer_out_t;

    function automatic logic limit_reached(input logic [31:0] cnt, input logic [31:0] lim);
        return cnt >= lim;
    endfunction

endpackage

// File: rtl/tsl_tick_gen.sv
module tsl_tick_gen #(
    parameter int DIV = 3580
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    assign tick = !hold && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end
endmodule

// File: rtl/tsl_steer_ctrl.sv
module tsl_steer_ctrl
    import tsl_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd,
    input  logic              tone_raw,
    input  logic              tick,
    input  logic [TICK_W-1:0] acc_lim,
    input  logic [TICK_W-1:0] rel_lim,
    output steer_out_t        flags
);
    steer_state_e      st_q, st_d;
    cnt_op_e           op;
    logic [TICK_W-1:0] cnt_q;
    logic              est_q, dv_q;
    logic              dv_set, dv_clr, load;
    logic              reached;

    assign reached = limit_reached(32'(cnt_q), 32'(acc_lim));

    always_comb begin
        st_d   = st_q;
        op     = CNT_HOLD;
        dv_set = 1'b0;
        dv_clr = 1'b0;
        load   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (est_q && reached) begin
                    st_d = ST_LATCH;
                    load = 1'b1;
                end else if (est_q && tick) begin
                    op = CNT_UP;
                end else if (!est_q && tick && (cnt_q != '0)) begin
                    op = CNT_DOWN;
                end
            end
            ST_LATCH: begin
                st_d   = ST_HELD;
                dv_set = 1'b1;
                op     = CNT_LOAD;
            end
            ST_HELD: begin
                if (est_q) begin
                    op = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    st_d   = ST_IDLE;
                    dv_clr = 1'b1;
                    op     = CNT_CLEAR;
                end else if (tick) begin
                    op = CNT_DOWN;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            est_q <= 1'b0;
            dv_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_IDLE;
        end else begin
            est_q <= tone_raw;
            st_q  <= st_d;
            if (dv_set) begin
                dv_q <= 1'b1;
            end else if (dv_clr) begin
                dv_q <= 1'b0;
            end
            unique case (op)
                CNT_UP:    cnt_q <= cnt_q + TICK_W'(1);
                CNT_DOWN:  cnt_q <= cnt_q - TICK_W'(1);
                CNT_LOAD:  cnt_q <= rel_lim;
                CNT_CLEAR: cnt_q <= '0;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign flags.est  = est_q;
    assign flags.dv   = dv_q;
    assign flags.load = load && !pd && !rst;
endmodule

// File: rtl/tsl_code_latch.sv
module tsl_code_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= code_in;
        end
    end
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch
    import tsl_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int TICK_W   = 8,
    parameter int TICK_DIV = 3580
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              tone_raw,
    input  logic [CODE_W-1:0] code_raw,
    input  logic [TICK_W-1:0] acc_ticks,
    input  logic [TICK_W-1:0] rel_ticks,
    input  logic              out_en,
    output logic              early_steer,
    output logic              data_valid,
    output logic [CODE_W-1:0] code_out
);
    logic              tick;
    steer_out_t        flags;
    logic [CODE_W-1:0] code_q;

    tsl_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .hold (pwr_down),
        .tick (tick)
    );

    tsl_steer_ctrl #(.TICK_W(TICK_W)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .pd       (pwr_down),
        .tone_raw (tone_raw),
        .tick     (tick),
        .acc_lim  (acc_ticks),
        .rel_lim  (rel_ticks),
        .flags    (flags)
    );

    tsl_code_latch #(.CODE_W(CODE_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (flags.load),
        .code_in (code_raw),
        .code_q  (code_q)
    );

    assign early_steer = flags.est;
    assign data_valid  = flags.dv;
    assign code_out    = out_en ? code_q : {CODE_W{1'bz}};
endmodule

// File: rtl/tone_steer_latch_chk.sv
module tone_steer_latch_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_down,
    input logic              tone_raw,
    input logic              out_en,
    input logic              early_steer,
    input logic              data_valid,
    input logic [CODE_W-1:0] code_q,
    input logic [CODE_W-1:0] code_out
);
    AST_EST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |=> (early_steer == $past(tone_raw))); // R2

    AST_DV_NEEDS_TONE: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(early_steer, 2)); // R3

    AST_CODE_BEFORE_DV: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $stable(code_q)); // R4

    AST_RELEASE_ABSENT: assert property (@(posedge clk) disable iff (rst)
        ($fell(data_valid) && !$past(pwr_down) && !$past(rst)) |-> !$past(early_steer)); // R6

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (data_valid && $past(data_valid)) |-> $stable(code_q)); // R8

    AST_DRIVE_CODE: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (code_out == code_q)); // R9

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!data_valid && !early_steer)); // R10

    AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> $stable(code_q)); // R10
endmodule

bind tone_steer_latch tone_steer_latch_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_down    (pwr_down),
    .tone_raw    (tone_raw),
    .out_en      (out_en),
    .early_steer (early_steer),
    .data_valid  (data_valid),
    .code_q      (code_q),
    .code_out    (code_out)
);

// File: tb/test_tone_steer_latch.sv
module test_tone_steer_latch;
    localparam int CW  = 4;
    localparam int TW  = 8;
    localparam int DIV = 4;
    localparam int NV  = 6;
    // {acc_ticks, rel_ticks, code}
    localparam logic [19:0] VECS [NV] = '{
        {8'd0, 8'd0, 4'h3},
        {8'd1, 8'd1, 4'hA},
        {8'd2, 8'd3, 4'h5},
        {8'd3, 8'd1, 4'hF},
        {8'd1, 8'd4, 4'h9},
        {8'd4, 8'd2, 4'h6}
    };

    logic          clk = 1'b0;
    logic          rst, pwr_down, tone_raw, out_en;
    logic [CW-1:0] code_raw;
    logic [TW-1:0] acc_ticks, rel_ticks;
    logic          early_steer, data_valid;
    logic [CW-1:0] code_out;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    tone_steer_latch #(.CODE_W(CW), .TICK_W(TW), .TICK_DIV(DIV)) i_tone_steer_latch (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .tone_raw(tone_raw),
        .code_raw(code_raw), .acc_ticks(acc_ticks), .rel_ticks(rel_ticks),
        .out_en(out_en), .early_steer(early_steer), .data_valid(data_valid),
        .code_out(code_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rise_lo(input int a);
        return (a == 0) ? 3 : (a - 1) * DIV + 4;
    endfunction
    function automatic int rise_hi(input int a);
        return a * DIV + 3;
    endfunction
    function automatic int fall_lo(input int l);
        return (l == 0) ? 2 : (l - 1) * DIV + 3;
    endfunction
    function automatic int fall_hi(input int l);
        return l * DIV + 2;
    endfunction

    // Edges until data_valid rises; the caller already took the first edge.
    task automatic count_rise(output int n, output logic [CW-1:0] prev);
        n = 1;
        prev = code_out;
        while (data_valid !== 1'b1 && n < 400) begin
            prev = code_out;
            step(1);
            n++;
        end
    endtask

    task automatic count_fall(output int n);
        n = 1;
        while (data_valid !== 1'b0 && n < 400) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int lo, hi;
        logic [CW-1:0] prev;
        bit ok;
        rst = 1'b1; pwr_down = 1'b0; tone_raw = 1'b0; out_en = 1'b1;
        code_raw = '0; acc_ticks = '0; rel_ticks = '0;
        step(3);
        rst = 1'b0;
        step(1);
        // R1
        chk(data_valid == 1'b0 && early_steer == 1'b0, "R1 flags", int'(data_valid), 0);
        chk(code_out == 4'h0, "R1 code", int'(code_out), 0);

        // Vector walk: R2 R3 R4 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            int a, l;
            logic [CW-1:0] c;
            a = int'(VECS[i][19:12]);
            l = int'(VECS[i][11:4]);
            c = VECS[i][3:0];
            acc_ticks = TW'(a);
            rel_ticks = TW'(l);
            code_raw  = c;
            tone_raw  = 1'b1;
            step(1);
            chk(early_steer == 1'b1, "R2 rise", int'(early_steer), 1);
            count_rise(n, prev);
            lo = rise_lo(a);
            hi = rise_hi(a);
            chk(n >= lo && n <= hi, (a == 0) ? "R11 accept" : "R3 accept", n, hi);
            chk(prev == c, "R4 code before dv", int'(prev), int'(c));
            code_raw = ~c;
            step(6);
            chk(code_out == c && data_valid, "R8 change ignored", int'(code_out), int'(c));
            tone_raw = 1'b0;
            step(1);
            chk(early_steer == 1'b0, "R2 fall", int'(early_steer), 0);
            count_fall(n);
            lo = fall_lo(l);
            hi = fall_hi(l);
            chk(n >= lo && n <= hi, (l == 0) ? "R11 release" : "R6 release", n, hi);
            step(3);
            chk(code_out == c, "R7 held after release", int'(code_out), int'(c));
        end

        // R5 short tone never accepted
        acc_ticks = 8'd5; rel_ticks = 8'd1; code_raw = 4'hB;
        tone_raw = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (data_valid) ok = 1'b0;
        end
        tone_raw = 1'b0;
        for (int k = 0; k < 60; k++) begin
            step(1);
            if (data_valid) ok = 1'b0;
        end
        chk(ok, "R5 short tone", int'(data_valid), 0);
        chk(code_out == 4'h6, "R7 no capture on short tone", int'(code_out), 6);

        // R6 drop-out bridged
        acc_ticks = 8'd1; rel_ticks = 8'd3; code_raw = 4'h2;
        tone_raw = 1'b1;
        step(1);
        count_rise(n, prev);
        chk(data_valid == 1'b1, "R6 setup accept", int'(data_valid), 1);
        tone_raw = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step(1);
            if (!data_valid) ok = 1'b0;
        end
        tone_raw = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (!data_valid) ok = 1'b0;
        end
        chk(ok, "R6 dropout bridged", int'(data_valid), 1);

        // R9 tri-state (a two-state simulator may resolve the floating bus to 0)
        out_en = 1'b0;
        step(1);
        chk((code_out === 4'bzzzz) || (code_out === 4'b0000), "R9 released bus", int'(code_out), 0);
        out_en = 1'b1;
        step(1);
        chk(code_out == 4'h2, "R9 driven bus", int'(code_out), 2);

        // R10 power-down while held
        pwr_down = 1'b1;
        step(1);
        chk(!data_valid && !early_steer, "R10 cleared", int'(data_valid), 0);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (data_valid || code_out != 4'h2) ok = 1'b0;
        end
        chk(ok, "R10 frozen with code kept", int'(code_out), 2);
        acc_ticks = 8'd2; code_raw = 4'hC;
        pwr_down = 1'b0;
        step(1);
        count_rise(n, prev);
        chk(n >= rise_lo(2) && n <= rise_hi(2), "R10 full reacceptance", n, rise_hi(2));
        chk(code_out == 4'hC, "R10 new code", int'(code_out), 12);
        tone_raw = 1'b0;
        step(1);
        count_fall(n);
        chk(data_valid == 1'b0, "R6 final release", int'(data_valid), 0);

        // R1 reset again after activity
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        step(1);
        chk(code_out == 4'h0 && !data_valid, "R1 second reset", int'(code_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule